// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls a 16-pin general-purpose I/O port through a small word-wide register interface: a 3-bit address, a write enable, write data and a combinational read data bus. For each pin, a mux bit chooses between the port's own I/O function and a primary peripheral. A direction bit chooses whether that pin is an input or an output. In I/O mode the pin is driven from an output latch. Software can change that latch with a whole-word write, or bit by bit through separate set, clear and toggle registers, so no read-modify-write is needed.

Inputs are first resynchronised to the clock. They can then be passed through a glitch filter. The filter samples the synchronised pin every 2n clocks, where n is a programmable 8-bit period. It accepts a new level only after six consecutive samples agree. A period of zero bypasses the filter. The filtered level is returned to software on a data read. It is also handed to the peripheral side.

Register offsets: 0 data, 1 set, 2 clear, 3 toggle, 4 mux, 5 direction, 6 qualification period.

Top module: `gpio_port`

## Requirements
- R1: For a pin whose mux bit is 0, `pinOut` and `pinOe` follow that pin's output latch bit and direction bit. For a pin whose mux bit is 1, they follow `perOut` and `perOe`.
- R2: After reset, the mux, direction, output latch and qualification period registers are all 0, so `pinOut` and `pinOe` are 0.
- R3: Offsets 4, 5 and 6 read back the mux, direction and qualification registers. The qualification register keeps only bits 7:0, and bits 15:8 read 0. Reads of offsets 1, 2, 3 and 7 return 0.
- R4: A write to offset 0 loads the whole output latch. A read of offset 0 returns, for each pin, the latch bit when its direction bit is 1 and the filtered input when it is 0.
- R5: Writing offset 1 sets to 1 every latch bit written as 1 and leaves the other bits unchanged. A write of 0 changes nothing.
- R6: Writing offset 2 clears every latch bit written as 1 and leaves the other bits unchanged.
- R7: Writing offset 3 inverts every latch bit written as 1 and leaves the other bits unchanged.
- R8: With the period set to 0, `perIn` shows a new pin level 3 clocks after the level changes: two synchroniser flops and one output register.
- R9: With the period set to n > 0, a changed input reaches `perIn` only after six consecutive samples, taken 2n clocks apart, have seen the new level. It must not appear within 8n clocks and must appear within 14n+6 clocks.
- R10: With the period set to n > 0, a pulse shorter than 2n clocks never reaches `perIn`.
- R11: `perIn` and the data read return the same filtered level whatever the mux and direction settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Register offset |
| busWe | input | 1 | Write enable |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` |
| pinIn | input | 16 | Pin levels from the pads |
| pinOut | output | 16 | Pin drive value |
| pinOe | output | 16 | Pin output enable |
| perOut | input | 16 | Peripheral output value |
| perOe | input | 16 | Peripheral output enable |
| perIn | output | 16 | Filtered pin level for the peripheral |

## Verification
The latch-update registers are tried with operands that overlap set and clear bits: 00F0, 1200 and 0F0F on a latch holding 1234. Results such as 12F4 and 0FFB can only come from a true OR, AND-NOT and XOR, so these patterns tell those operations apart from each other and from a plain load. Mixed direction (FF00) and mixed mux (00FF) masks, with different values on the latch, the filtered input and the peripheral, show which source drives each half of the word. The filter is driven three ways: with the period at zero (plain resynchronisation), with a step at period 3 (checked both early and late), and with a one-clock pulse at period 3. Together these separate a working filter from a bypass and from a filter that never lets anything through.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DAT  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_SET  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_TGL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MUX  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_QUAL = 3'd6;

  typedef struct packed {
    logic wrDat;
    logic wrSet;
    logic wrClr;
    logic wrTgl;
    logic wrMux;
    logic wrDir;
    logic wrQual;
  } strobes_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_DAT,
    RD_MUX,
    RD_DIR,
    RD_QUAL
  } rdSel_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          strb,
  output rdSel_t            rdSel
);
  always_comb begin
    strb        = '0;
    strb.wrDat  = busWe && (busAddr == OFS_DAT);
    strb.wrSet  = busWe && (busAddr == OFS_SET);
    strb.wrClr  = busWe && (busAddr == OFS_CLR);
    strb.wrTgl  = busWe && (busAddr == OFS_TGL);
    strb.wrMux  = busWe && (busAddr == OFS_MUX);
    strb.wrDir  = busWe && (busAddr == OFS_DIR);
    strb.wrQual = busWe && (busAddr == OFS_QUAL);
  end

  always_comb begin
    case (busAddr)
      OFS_DAT:  rdSel = RD_DAT;
      OFS_MUX:  rdSel = RD_MUX;
      OFS_DIR:  rdSel = RD_DIR;
      OFS_QUAL: rdSel = RD_QUAL;
      default:  rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/gpio_qual.sv
module gpio_qual #(
  parameter int WIDTH  = 16,
  parameter int QUAL_W = 8,
  parameter int HOLD   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic [QUAL_W-1:0] qualPrd,
  output logic [WIDTH-1:0]  qualOut
);
  localparam int CNT_W  = QUAL_W + 1;
  localparam int HCNT_W = $clog2(HOLD + 1);
  localparam logic [HCNT_W-1:0] HOLD_V = HCNT_W'(HOLD);

  logic [WIDTH-1:0] syncA, syncB;
  logic [CNT_W-1:0] preCnt, preLim;
  logic             bypass, tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  assign bypass = (qualPrd == '0);
  assign preLim = {qualPrd, 1'b0} - CNT_W'(1);
  assign tick   = !bypass && (preCnt >= preLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (bypass || tick)  preCnt <= '0;
    else                      preCnt <= preCnt + CNT_W'(1);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic              lastSmp;
    logic [HCNT_W-1:0] runCnt;
    logic [HCNT_W-1:0] runNext;

    always_comb begin
      if (syncB[i] != lastSmp)  runNext = HCNT_W'(1);
      else if (runCnt < HOLD_V) runNext = runCnt + HCNT_W'(1);
      else                      runNext = runCnt;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lastSmp    <= 1'b0;
        runCnt     <= HOLD_V;
        qualOut[i] <= 1'b0;
      end else if (bypass) begin
        lastSmp    <= syncB[i];
        runCnt     <= HOLD_V;
        qualOut[i] <= syncB[i];
      end else if (tick) begin
        lastSmp <= syncB[i];
        runCnt  <= runNext;
        if (runNext == HOLD_V) qualOut[i] <= syncB[i];
      end
    end
  end

  // R9: between sample points the filtered level cannot move
  a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (!bypass && !tick) |=> $stable(qualOut));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int QUAL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  rdSel_t            rdSel,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  qualIn,
  input  logic [WIDTH-1:0]  perOut,
  input  logic [WIDTH-1:0]  perOe,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic [QUAL_W-1:0] qualPrd
);
  logic [WIDTH-1:0] outLatch, muxReg, dirReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outLatch <= '0;
    else if (strb.wrDat)   outLatch <= wdata;
    else if (strb.wrSet)   outLatch <= outLatch | wdata;
    else if (strb.wrClr)   outLatch <= outLatch & ~wdata;
    else if (strb.wrTgl)   outLatch <= outLatch ^ wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxReg  <= '0;
      dirReg  <= '0;
      qualPrd <= '0;
    end else begin
      if (strb.wrMux)  muxReg  <= wdata;
      if (strb.wrDir)  dirReg  <= wdata;
      if (strb.wrQual) qualPrd <= wdata[QUAL_W-1:0];
    end
  end

  assign pinOut = (muxReg & perOut) | (~muxReg & outLatch);
  assign pinOe  = (muxReg & perOe)  | (~muxReg & dirReg);

  always_comb begin
    case (rdSel)
      RD_DAT:  rdata = (dirReg & outLatch) | (~dirReg & qualIn);
      RD_MUX:  rdata = muxReg;
      RD_DIR:  rdata = dirReg;
      RD_QUAL: rdata = {{(WIDTH-QUAL_W){1'b0}}, qualPrd};
      default: rdata = '0;
    endcase
  end

  a_r5_set_bits_high: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> ((outLatch & $past(wdata)) == $past(wdata)));
  a_r6_clear_bits_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((outLatch & $past(wdata)) == '0));
  a_r7_toggle_only_marked: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTgl |=> ((outLatch ^ $past(outLatch)) == $past(wdata)));
  a_r3_dir_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirReg));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int QUAL_W = 8,
  parameter int HOLD   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  input  logic [WIDTH-1:0]  perOut,
  input  logic [WIDTH-1:0]  perOe,
  output logic [WIDTH-1:0]  perIn
);
  strobes_t          strb;
  rdSel_t            rdSel;
  logic [QUAL_W-1:0] qualPrd;
  logic [WIDTH-1:0]  qualVal;

  gpio_ctrl u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strb(strb), .rdSel(rdSel)
  );

  gpio_datapath #(.WIDTH(WIDTH), .QUAL_W(QUAL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wdata(busWdata),
    .qualIn(qualVal), .perOut(perOut), .perOe(perOe), .rdata(busRdata),
    .pinOut(pinOut), .pinOe(pinOe), .qualPrd(qualPrd)
  );

  gpio_qual #(.WIDTH(WIDTH), .QUAL_W(QUAL_W), .HOLD(HOLD)) u_qual (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .qualPrd(qualPrd), .qualOut(qualVal)
  );

  assign perIn = qualVal;
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata, pinOut, pinOe, perIn;
  logic [15:0] pinIn = '0, perOut = '0, perOe = '0;

  always #4 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .perOut(perOut), .perOe(perOe),
    .perIn(perIn)
  );

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t queue_q[$];
  int    pushed = 0, popped = 0, checks = 0, failures = 0;
  bit    finished = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [15:0] act;
      wait (queue_q.size() > 0);
      it = queue_q.pop_front();
      case (it.sel)
        0: act = busRdata;
        1: act = pinOut;
        2: act = pinOe;
        default: act = perIn;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
      popped++;
    end
  end

  task automatic expect_val(input int sel, input logic [2:0] addr,
                            input logic [15:0] exp, input string tag);
    item_t it;
    busAddr = addr;
    #1;
    it.sel = sel; it.exp = exp; it.tag = tag;
    queue_q.push_back(it);
    pushed++;
    wait (popped == pushed);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] addr, input logic [15:0] d);
    @(negedge clk);
    busAddr = addr; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clocks(3);
    rstN = 1'b1;
    clocks(1);
    // R2 reset state
    expect_val(1, 3'd0, 16'h0000, "R2 pinOut after reset");
    expect_val(2, 3'd0, 16'h0000, "R2 pinOe after reset");
    expect_val(0, 3'd4, 16'h0000, "R2 mux after reset");
    expect_val(0, 3'd6, 16'h0000, "R2 qual after reset");

    // R8 pass-through with period 0
    pinIn = 16'hA5C3;
    clocks(2);
    expect_val(3, 3'd0, 16'h0000, "R8 not yet through");
    clocks(2);
    expect_val(3, 3'd0, 16'hA5C3, "R8 perIn follows pin");
    expect_val(0, 3'd0, 16'hA5C3, "R4 read inputs");

    // R4 data write with all outputs
    wr(3'd5, 16'hFFFF);
    wr(3'd0, 16'h1234);
    expect_val(1, 3'd0, 16'h1234, "R1 pinOut from latch");
    expect_val(2, 3'd0, 16'hFFFF, "R1 pinOe from dir");
    expect_val(0, 3'd0, 16'h1234, "R4 read latch");
    expect_val(3, 3'd0, 16'hA5C3, "R11 perIn with outputs");

    wr(3'd1, 16'h00F0);
    expect_val(1, 3'd0, 16'h12F4, "R5 set");
    wr(3'd2, 16'h1200);
    expect_val(1, 3'd0, 16'h00F4, "R6 clear");
    wr(3'd3, 16'h0F0F);
    expect_val(1, 3'd0, 16'h0FFB, "R7 toggle");
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000);
    expect_val(1, 3'd0, 16'h0FFB, "R5 zero writes no effect");
    expect_val(0, 3'd1, 16'h0000, "R3 read set");
    expect_val(0, 3'd2, 16'h0000, "R3 read clear");
    expect_val(0, 3'd3, 16'h0000, "R3 read toggle");
    expect_val(0, 3'd7, 16'h0000, "R3 read unused");

    // R4 mixed direction
    wr(3'd5, 16'hFF00);
    expect_val(0, 3'd0, 16'h0FC3, "R4 mixed dir read");
    expect_val(0, 3'd5, 16'hFF00, "R3 dir readback");

    // R1 mixed mux
    perOut = 16'h5555; perOe = 16'h0F0F;
    wr(3'd4, 16'h00FF);
    expect_val(1, 3'd0, 16'h0F55, "R1 mixed mux pinOut");
    expect_val(2, 3'd0, 16'hFF0F, "R1 mixed mux pinOe");
    expect_val(0, 3'd4, 16'h00FF, "R3 mux readback");
    expect_val(3, 3'd0, 16'hA5C3, "R11 perIn with mux");

    // R9 filtered step, period 3
    wr(3'd6, 16'hAB03);
    expect_val(0, 3'd6, 16'h0003, "R3 qual upper bits dropped");
    pinIn = 16'h5A3C;
    clocks(24);
    expect_val(3, 3'd0, 16'hA5C3, "R9 not early");
    clocks(24);
    expect_val(3, 3'd0, 16'h5A3C, "R9 arrives");
    expect_val(0, 3'd0, 16'h0F3C, "R11 read filtered");

    // R10 one-clock glitch
    pinIn = 16'hFFFF;
    clocks(1);
    pinIn = 16'h5A3C;
    clocks(60);
    expect_val(3, 3'd0, 16'h5A3C, "R10 glitch rejected");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule